// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a memory-mapped watchdog. A 16-bit up-counter advances on prescaled ticks and is compared with a programmable 16-bit limit. Once the count has reached the limit and one more prescaled tick arrives, a reset request goes high. The request stays high until the block itself is reset by hardware. Software keeps the system alive by writing to the counter register, which clears the count.

The count source can be the system clock, a slow real-time clock input, or an external clock input. Each source has its own select bit. The two slow inputs pass through a two-flop synchronizer and a rising-edge detector, which turns them into one-cycle strobes in the system clock domain. A prescaler then divides the chosen ticks by 1, 4, 16, 64, 256 or 1024.

Access is through a small register bus. It has a word address, 16-bit write data, two byte strobes, a write enable and registered read data. Read data appears one cycle after the address is presented.

Top module: `wdt_prescaled_timer`

## Requirements
- R1: After hardware reset, the registers read as follows: limit (word 0, byte address 0x0) = 0xFFFF, enable (word 1, 0x4) = 0, counter (word 2, 0x8) = 0, control (word 3, 0xC) = 0. The reset request output is 0.
- R2: Every register reads back its current value, one cycle after the address is presented. Control keeps only bits [5:0] and reads 0 above them. Enable keeps only bit 0. An access with address bits [1:0] not equal to zero is ignored.
- R3: Byte strobe bit 0 writes data bits [7:0] and strobe bit 1 writes bits [15:8]. A byte write on strobe 0 alone is enough to change the enable bit or the control register.
- R4: With the divider at 1 and the system clock selected, after the enabling write the reset request rises exactly limit+1 clock cycles later. The request rises only when the count equals the limit on a tick, and the count then stops advancing. A limit of 0 gives a request one cycle after enabling.
- R5: Control bits [5:3] hold the divide code: 0, 1, 2, 3, 4 and 5 divide by 1, 4, 16, 64, 256 and 1024. Codes 6 and 7 also divide by 1024. From the enabling write, the request rises after divide × (limit+1) system cycles. The prescaler restarts whenever enable is 0 or control is written.
- R6: A write of any value to the counter register clears the count to 0. Writing it more often than the timeout prevents the request.
- R7: When enable bit 0 is 0, the count holds its value.
- R8: Control bit 0 selects the system clock, bit 1 the slow real-time clock input, and bit 2 the external clock input. Each rising edge of a selected slow input gives one tick. Edges on unselected inputs do nothing. With no select bit set, the count does not advance.
- R9: Once high, the reset request stays high. While it is high, the count holds its value and counter writes or disabling have no effect. Only hardware reset clears it.
- R10: The reprogramming order disable, write divider, write limit, clear counter, write divider with source, enable raises no request on the way, even when the old count is above the new limit. Timing after the enable then follows R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the register |
| bus_wdata | input | 16 | Write data |
| bus_strb | input | 2 | Byte strobes for a write |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 16 | Registered read data |
| rtc_clk_in | input | 1 | Slow real-time clock, asynchronous |
| ext_clk_in | input | 1 | External clock, asynchronous |
| wdt_rst_req | output | 1 | Sticky reset request |

## Verification
The timeout is tried with every divide code, including the two spare codes, and with limits of 0 and above. Each case pins the exact cycle of the request, so an off-by-one in the compare or in the prescaler period is caught. Slow-input tests count edges on a selected input while pulsing an unselected one, which shows whether selection, synchronization and edge detection are right. Keepalive, disable and request-stickiness tests separate a counter that is cleared, one that is held, and one that wrongly keeps running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SRC_N  = 3;
  localparam int CODE_W = 3;
  localparam int CTRL_W = SRC_N + CODE_W;

  typedef enum logic [1:0] {
    REG_LIMIT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_COUNT  = 2'd2,
    REG_CTRL   = 2'd3
  } wdt_reg_e;

  typedef struct packed {
    logic [CODE_W-1:0] div_code;
    logic [SRC_N-1:0]  src_sel;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [2:0] shr;
    always_ff @(posedge clk) begin
      if (rst) shr <= '0;
      else     shr <= {shr[1:0], raw[i]};
    end
    assign pulse[i] = shr[1] & ~shr[2];
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int STAGES = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic              src_tick,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CW = 2 * STAGES;

  logic [CW-1:0] pcnt;
  logic [CW-1:0] limit;
  logic [CW:0]   span;
  int unsigned   stage;

  always_comb begin
    stage = (int'(code) > STAGES) ? STAGES : int'(code);
    span  = (CW+1)'(1) << (2 * stage);
    limit = span[CW-1:0] - 1'b1;
  end

  assign tick = run && src_tick && (pcnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) pcnt <= '0;
    else if (src_tick)           pcnt <= (pcnt == limit) ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      req   <= 1'b0;
    end else if (!req) begin
      if (clear)                        count <= '0;
      else if (tick && count == limit)  req   <= 1'b1;
      else if (tick)                    count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_prescaled_timer.sv
module wdt_prescaled_timer
  import wdt_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 4,
  parameter int PRE_STAGES = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_strb,
  input  logic                bus_we,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                rtc_clk_in,
  input  logic                ext_clk_in,
  output logic                wdt_rst_req
);
  localparam int STRB_W = DATA_W / 8;

  logic [DATA_W-1:0] limit_q;
  logic              en_q;
  wdt_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] count_w;
  logic [1:0]        slow_pulse;
  logic [SRC_N-1:0]  src_sel_w;
  logic              aligned;
  wdt_reg_e          sel;
  logic              wr_limit, wr_en, wr_ctrl, cnt_clr;
  logic              src_tick, pre_tick;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign sel       = wdt_reg_e'(bus_addr[3:2]);
  assign wr_limit  = bus_we && aligned && sel == REG_LIMIT;
  assign wr_en     = bus_we && aligned && sel == REG_ENABLE && bus_strb[0];
  assign wr_ctrl   = bus_we && aligned && sel == REG_CTRL && bus_strb[0];
  assign cnt_clr   = bus_we && aligned && sel == REG_COUNT && (|bus_strb);
  assign src_sel_w = ctrl_q.src_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '1;
      en_q    <= 1'b0;
      ctrl_q  <= '0;
    end else begin
      for (int b = 0; b < STRB_W; b++)
        if (wr_limit && bus_strb[b]) limit_q[8*b +: 8] <= bus_wdata[8*b +: 8];
      if (wr_en)   en_q   <= bus_wdata[0];
      if (wr_ctrl) ctrl_q <= wdt_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  wdt_edge_sync #(.N(2)) u_sync (
    .clk(clk), .rst(rst),
    .raw({ext_clk_in, rtc_clk_in}),
    .pulse(slow_pulse)
  );

  assign src_tick = |(ctrl_q.src_sel & {slow_pulse, 1'b1});

  wdt_prescale #(.STAGES(PRE_STAGES), .CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst(rst), .run(en_q), .restart(wr_ctrl),
    .src_tick(src_tick), .code(ctrl_q.div_code), .tick(pre_tick)
  );

  wdt_count_core #(.W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .tick(pre_tick), .clear(cnt_clr),
    .limit(limit_q), .count(count_w), .req(wdt_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (sel)
        REG_LIMIT:  bus_rdata <= limit_q;
        REG_ENABLE: bus_rdata <= DATA_W'(en_q);
        REG_COUNT:  bus_rdata <= count_w;
        REG_CTRL:   bus_rdata <= DATA_W'(ctrl_q);
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_prescaled_timer_sva.sv
module wdt_prescaled_timer_sva #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cnt,
  input logic [W-1:0] limit_v,
  input logic         req,
  input logic         en,
  input logic         cnt_clr,
  input logic [2:0]   src_sel
);
  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    req |=> req); // R9
  AST_HOLD_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    req |=> $stable(cnt)); // R9
  AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> ($past(cnt) == $past(limit_v))); // R4
  AST_STEP_OR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt) |-> (cnt == '0 || cnt == W'($past(cnt) + 1'b1))); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_clr) |=> $stable(cnt)); // R7
  AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 3'b000 && !cnt_clr) |=> $stable(cnt)); // R8
endmodule

bind wdt_prescaled_timer wdt_prescaled_timer_sva #(.W(DATA_W)) u_sva (
  .clk(clk), .rst(rst), .cnt(count_w), .limit_v(limit_q),
  .req(wdt_rst_req), .en(en_q), .cnt_clr(cnt_clr), .src_sel(src_sel_w)
);

// File: tb/wdt_prescaled_timer_test.sv
`timescale 1ns/1ps
module wdt_prescaled_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_strb = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_rdata;
  logic        rtc_clk_in = 1'b0;
  logic        ext_clk_in = 1'b0;
  logic        wdt_rst_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wdt_prescaled_timer uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_strb(bus_strb), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .rtc_clk_in(rtc_clk_in), .ext_clk_in(ext_clk_in), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] s = 2'b11);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_strb = s; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_strb = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_in(input bit use_ext, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use_ext) ext_clk_in = 1'b1; else rtc_clk_in = 1'b1;
      repeat (5) @(negedge clk);
      if (use_ext) ext_clk_in = 1'b0; else rtc_clk_in = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  // Reprogramming sequence; returns at the negedge right after the enabling edge
  task automatic reprogram(input int code, input logic [15:0] lim, input logic [2:0] src);
    wr(4'h4, 16'h0000);
    wr(4'hC, 16'(code << 3));
    wr(4'h0, lim);
    wr(4'h8, 16'h0000);
    wr(4'hC, 16'((code << 3) | src));
    chk("R10 no request before enable", wdt_rst_req, 0);
    wr(4'h4, 16'h0001);
  endtask

  task automatic test_reset_values();
    logic [15:0] v;
    do_reset();
    chk("R1 request", wdt_rst_req, 0);
    rd(4'h0, v); chk("R1 limit", v, 16'hFFFF);
    rd(4'h4, v); chk("R1 enable", v, 0);
    rd(4'h8, v); chk("R1 counter", v, 0);
    rd(4'hC, v); chk("R1 control", v, 0);
  endtask

  task automatic test_readback();
    logic [15:0] v;
    do_reset();
    wr(4'h0, 16'h1234); rd(4'h0, v); chk("R2 limit readback", v, 16'h1234);
    wr(4'hC, 16'hFFFF); rd(4'hC, v); chk("R2 control width", v, 16'h003F);
    wr(4'hC, 16'h0000);
    wr(4'h1, 16'h5555); rd(4'h0, v); chk("R2 misaligned ignored", v, 16'h1234);
    wr(4'h0, 16'hABCD, 2'b01); rd(4'h0, v); chk("R3 low strobe", v, 16'h12CD);
    wr(4'h0, 16'h5600, 2'b10); rd(4'h0, v); chk("R3 high strobe", v, 16'h56CD);
    wr(4'h4, 16'hFF01, 2'b01); rd(4'h4, v); chk("R3 enable byte write", v, 16'h0001);
    wr(4'h4, 16'h0000);
  endtask

  task automatic timed_case(input int code, input logic [15:0] lim, input int edges, input string tag);
    do_reset();
    reprogram(code, lim, 3'b001);
    if (edges > 1) repeat (edges - 1) @(negedge clk);
    chk({tag, " quiet one cycle early"}, wdt_rst_req, 0);
    @(negedge clk);
    chk({tag, " request on time"}, wdt_rst_req, 1);
  endtask

  task automatic test_reprogram();
    do_reset();
    reprogram(0, 16'd40, 3'b001);
    repeat (30) @(negedge clk);
    reprogram(0, 16'd10, 3'b001);
    repeat (10) @(negedge clk);
    chk("R10 quiet after reprogram", wdt_rst_req, 0);
    @(negedge clk);
    chk("R10 request with new limit", wdt_rst_req, 1);
  endtask

  task automatic test_keepalive_sticky();
    logic [15:0] v;
    do_reset();
    reprogram(0, 16'd20, 3'b001);
    for (int i = 0; i < 6; i++) begin
      repeat (12) @(negedge clk);
      wr(4'h8, 16'hBEEF);
    end
    chk("R6 keepalive holds off request", wdt_rst_req, 0);
    rd(4'h8, v); chk("R6 counter low after keepalive", 32'(v < 16'd5), 1);
    repeat (30) @(negedge clk);
    chk("R9 request raised", wdt_rst_req, 1);
    rd(4'h8, v); chk("R9 counter held at limit", v, 16'd20);
    wr(4'h8, 16'h0000);
    rd(4'h8, v); chk("R9 counter write ignored", v, 16'd20);
    wr(4'h4, 16'h0000);
    chk("R9 request stays after disable", wdt_rst_req, 1);
    do_reset();
    chk("R9 hardware reset clears request", wdt_rst_req, 0);
  endtask

  task automatic test_enable_stop();
    logic [15:0] v1, v2;
    do_reset();
    reprogram(0, 16'd500, 3'b001);
    repeat (10) @(negedge clk);
    wr(4'h4, 16'h0000);
    rd(4'h8, v1);
    repeat (20) @(negedge clk);
    rd(4'h8, v2);
    chk("R7 count held while disabled", v2, v1);
    chk("R7 count had advanced", 32'(v1 > 16'd5), 1);
  endtask

  task automatic test_sources();
    logic [15:0] v;
    do_reset();
    reprogram(0, 16'd1000, 3'b000);
    repeat (40) @(negedge clk);
    pulse_in(1'b0, 2);
    rd(4'h8, v); chk("R8 no source no advance", v, 0);
    wr(4'hC, 16'h0002);
    pulse_in(1'b0, 7);
    rd(4'h8, v); chk("R8 slow clock edges counted", v, 7);
    pulse_in(1'b1, 3);
    rd(4'h8, v); chk("R8 unselected external ignored", v, 7);
    wr(4'hC, 16'h0004);
    pulse_in(1'b1, 2);
    pulse_in(1'b0, 2);
    rd(4'h8, v); chk("R8 external edges counted", v, 9);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset_values();
    test_readback();
    timed_case(0, 16'd5, 6,    "R4 div1 limit5");
    timed_case(0, 16'd0, 1,    "R4 div1 limit0");
    timed_case(1, 16'd3, 16,   "R5 div4");
    timed_case(2, 16'd1, 32,   "R5 div16");
    timed_case(3, 16'd0, 64,   "R5 div64");
    timed_case(4, 16'd0, 256,  "R5 div256");
    timed_case(5, 16'd0, 1024, "R5 div1024");
    timed_case(6, 16'd0, 1024, "R5 code6");
    timed_case(7, 16'd0, 1024, "R5 code7");
    test_reprogram();
    test_keepalive_sticky();
    test_enable_stop();
    test_sources();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule